// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block sits behind a bit-level I2C receiver. After each START it looks at the bytes that the receiver has already assembled and decides whether the local slave is the one being addressed. It tells the receiver when to drive an acknowledge in the 9th clock, and it reports the transfer direction. It also reports when a general call was taken.

The own address can be programmed as 7 bits or 10 bits. A 10-bit address arrives as a header byte followed by a low byte. Software can switch general call matching on or off. After a 10-bit write has matched, the master may issue a repeated START and send the header with the read bit set, with no second byte. The block remembers the earlier match so that it can accept this. The block does not shift bits, watch SCL, or handle the data phase.

Received bytes come in on a valid/ready stream. `rx_ready` is held high whenever the block is out of reset, so the block never applies back-pressure. A byte is consumed in every cycle in which `rx_valid` and `rx_ready` are both high. The sender must hold `rx_data` stable only while `rx_valid` is high. START, STOP and configuration are plain level or pulse pins.

Top module: `i2c_addr_match`

## Requirements
- R1: `rx_ready` is low during reset and high at all times after it. A byte is accepted in a cycle with `rx_valid` and `rx_ready` high. Every response to that byte appears on the outputs in the next cycle, and `ack_req` is never high without a byte accepted in the previous cycle.
- R2: In 7-bit mode (`cfg_ten_bit`=0), a first byte whose bits [7:1] equal `cfg_own_addr[6:0]` (byte not 0x00) gives a one-cycle pulse on both `ack_req` and `match_pulse`. `rd_dir` takes bit 0 of that byte, where 1 means read.
- R3: A first byte that matches nothing gives no `ack_req` and no `match_pulse`. All later bytes are ignored until the next START or STOP.
- R4: With `cfg_gc_en`=1, a first byte of 0x00 gives `ack_req` and `match_pulse` and sets `gc_hit`=1 and `rd_dir`=0. With `cfg_gc_en`=0, a byte of 0x00 is ignored even when the own address is zero.
- R5: In 10-bit mode, a first byte of the form 11110, `cfg_own_addr[9:8]`, 0 is acknowledged with `ack_req` only, with no `match_pulse`. A header whose bits [2:1] differ from the own address is not acknowledged.
- R6: In 10-bit mode, after an accepted header, a second byte equal to `cfg_own_addr[7:0]` gives `ack_req` and `match_pulse` with `rd_dir`=0. A second byte that differs gives no acknowledge, and the bytes after it are ignored.
- R7: After a 10-bit write match, a repeated START followed by the header with bit 0 = 1 gives `ack_req` and `match_pulse` with `rd_dir`=1, with no second byte. This state is remembered until a STOP. After a STOP, or with no earlier write match, the read header is not acknowledged.
- R8: A `start_evt` or `stop_evt` pulse clears `rd_dir` and `gc_hit` in the next cycle and puts the block back to waiting for a first address byte. A byte presented in the same cycle as such a pulse is dropped.
- R9: During reset, `ack_req`, `match_pulse`, `rd_dir` and `gc_hit` are all low.
- R10: Once an address has matched, further bytes give no `ack_req` and no `match_pulse` until the next START or STOP. `rd_dir` and `gc_hit` keep their values through those bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ten_bit | input | 1 | 1 selects the 10-bit own address, 0 selects 7-bit |
| cfg_own_addr | input | 10 | Own slave address; only bits [6:0] are used in 7-bit mode |
| cfg_gc_en | input | 1 | Enables general call matching |
| start_evt | input | 1 | One-cycle pulse for a START or repeated START |
| stop_evt | input | 1 | One-cycle pulse for a STOP |
| rx_valid | input | 1 | A received byte is present |
| rx_ready | output | 1 | Block can accept a byte (high whenever out of reset) |
| rx_data | input | 8 | Received byte, MSB first on the wire |
| ack_req | output | 1 | Pulse: acknowledge in the 9th clock of the byte just accepted |
| match_pulse | output | 1 | Pulse: the full own or general call address has matched |
| rd_dir | output | 1 | Direction of the matched transfer, 1 = read |
| gc_hit | output | 1 | The current match is a general call |

## Verification
The bench tests the 10-bit read shortcut in three situations: after a write match, after a STOP, and with no earlier match. A matcher that forgot the earlier match would refuse a valid read. A matcher that never cleared it would claim a read that belongs to another slave. The bench sends a 0x00 byte with general call disabled and the own address set to zero, which catches a 7-bit compare that does not exclude the general call byte. It also sends bytes after a match, after a wrong header and after a wrong low byte, which catches a state machine that acknowledges bytes it should ignore. A byte that arrives in the same cycle as START checks that the event wins and that the byte is not decoded against stale state.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
  localparam int unsigned AM_BYTE_W = 8;
  localparam int unsigned AM_ADDR_W = 10;
  localparam logic [4:0] AM_HDR10 = 5'b11110;

  typedef enum logic [1:0] {
    AM_FIRST  = 2'd0,
    AM_LOW    = 2'd1,
    AM_IGNORE = 2'd2
  } am_state_e;
endpackage

// File: rtl/i2c_am_first_decode.sv
module i2c_am_first_decode
  import i2c_am_pkg::*;
#(
  parameter int unsigned BYTE_W = AM_BYTE_W,
  parameter int unsigned ADDR_W = AM_ADDR_W,
  localparam int unsigned HI_W  = ADDR_W - BYTE_W,
  localparam int unsigned S7_W  = BYTE_W - 1,
  localparam int unsigned PFX_W = BYTE_W - 1 - HI_W
) (
  input  logic [BYTE_W-1:0] byte_in,
  input  logic [S7_W-1:0]   own_seven,
  input  logic [HI_W-1:0]   own_hi,
  input  logic              gc_en,
  output logic              hit_seven,
  output logic              hit_gc,
  output logic              hdr_ok,
  output logic              rw_bit
);
  logic              is_zero;
  logic [S7_W-1:0]   bit_eq;

  assign is_zero = (byte_in == '0);
  assign rw_bit  = byte_in[0];
  assign hit_gc  = is_zero && gc_en;

  // per-bit compare of the 7-bit address field
  for (genvar i = 0; i < S7_W; i++) begin : g_seven_cmp
    assign bit_eq[i] = (byte_in[i+1] == own_seven[i]);
  end
  assign hit_seven = (&bit_eq) && !is_zero;

  if (HI_W > 0) begin : g_hdr
    assign hdr_ok = (byte_in[BYTE_W-1 -: PFX_W] == AM_HDR10[PFX_W-1:0]) &&
                    (byte_in[HI_W:1] == own_hi);
  end else begin : g_no_hdr
    assign hdr_ok = 1'b0;
  end
endmodule

// File: rtl/i2c_am_low_compare.sv
module i2c_am_low_compare
  import i2c_am_pkg::*;
#(
  parameter int unsigned BYTE_W = AM_BYTE_W
) (
  input  logic [BYTE_W-1:0] byte_in,
  input  logic [BYTE_W-1:0] own_lo,
  output logic              low_eq
);
  assign low_eq = (byte_in == own_lo);
endmodule

// File: rtl/i2c_am_ctrl.sv
module i2c_am_ctrl
  import i2c_am_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_evt,
  input  logic stop_evt,
  input  logic take,
  input  logic ten_bit,
  input  logic hit_seven,
  input  logic hit_gc,
  input  logic hdr_ok,
  input  logic rw_bit,
  input  logic low_eq,
  output logic ack_req,
  output logic match_pulse,
  output logic rd_dir,
  output logic gc_hit
);
  am_state_e state;
  logic      armed;
  logic      evt;

  assign evt = start_evt || stop_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= AM_FIRST;
      armed       <= 1'b0;
      ack_req     <= 1'b0;
      match_pulse <= 1'b0;
      rd_dir      <= 1'b0;
      gc_hit      <= 1'b0;
    end else begin
      ack_req     <= 1'b0;
      match_pulse <= 1'b0;
      if (evt) begin
        state  <= AM_FIRST;
        rd_dir <= 1'b0;
        gc_hit <= 1'b0;
        if (stop_evt) armed <= 1'b0;
      end else if (take) begin
        unique case (state)
          AM_FIRST: begin
            state <= AM_IGNORE;
            if (hit_gc) begin
              ack_req     <= 1'b1;
              match_pulse <= 1'b1;
              gc_hit      <= 1'b1;
              rd_dir      <= 1'b0;
            end else if (!ten_bit && hit_seven) begin
              ack_req     <= 1'b1;
              match_pulse <= 1'b1;
              rd_dir      <= rw_bit;
            end else if (ten_bit && hdr_ok && !rw_bit) begin
              ack_req <= 1'b1;
              state   <= AM_LOW;
            end else if (ten_bit && hdr_ok && rw_bit && armed) begin
              ack_req     <= 1'b1;
              match_pulse <= 1'b1;
              rd_dir      <= 1'b1;
            end
          end
          AM_LOW: begin
            state <= AM_IGNORE;
            if (low_eq) begin
              ack_req     <= 1'b1;
              match_pulse <= 1'b1;
              rd_dir      <= 1'b0;
              armed       <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_match_acked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> ack_req);

  assert_ack_needs_byte_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |-> $past(take));

  assert_event_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> (!rd_dir && !gc_hit && !ack_req && state == AM_FIRST));

  assert_stop_disarms_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !armed);

  assert_low_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == AM_LOW && take && !evt) |=> (ack_req == $past(low_eq)));

  assert_ignore_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == AM_IGNORE && take && !evt) |=> (!ack_req && $stable(rd_dir) && $stable(gc_hit)));
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_am_pkg::*;
#(
  parameter int unsigned BYTE_W = AM_BYTE_W,
  parameter int unsigned ADDR_W = AM_ADDR_W,
  localparam int unsigned HI_W  = ADDR_W - BYTE_W,
  localparam int unsigned S7_W  = BYTE_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_ten_bit,
  input  logic [ADDR_W-1:0] cfg_own_addr,
  input  logic              cfg_gc_en,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              ack_req,
  output logic              match_pulse,
  output logic              rd_dir,
  output logic              gc_hit
);
  logic take;
  logic hit_seven, hit_gc, hdr_ok, rw_bit, low_eq;

  always_ff @(posedge clk) begin
    if (!rst_n) rx_ready <= 1'b0;
    else        rx_ready <= 1'b1;
  end

  assign take = rx_valid && rx_ready;

  i2c_am_first_decode #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_first (
    .byte_in   (rx_data),
    .own_seven (cfg_own_addr[S7_W-1:0]),
    .own_hi    (cfg_own_addr[ADDR_W-1 -: HI_W]),
    .gc_en     (cfg_gc_en),
    .hit_seven (hit_seven),
    .hit_gc    (hit_gc),
    .hdr_ok    (hdr_ok),
    .rw_bit    (rw_bit)
  );

  i2c_am_low_compare #(.BYTE_W(BYTE_W)) u_low (
    .byte_in (rx_data),
    .own_lo  (cfg_own_addr[BYTE_W-1:0]),
    .low_eq  (low_eq)
  );

  i2c_am_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_evt   (start_evt),
    .stop_evt    (stop_evt),
    .take        (take),
    .ten_bit     (cfg_ten_bit),
    .hit_seven   (hit_seven),
    .hit_gc      (hit_gc),
    .hdr_ok      (hdr_ok),
    .rw_bit      (rw_bit),
    .low_eq      (low_eq),
    .ack_req     (ack_req),
    .match_pulse (match_pulse),
    .rd_dir      (rd_dir),
    .gc_hit      (gc_hit)
  );

  assert_gc_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gc_hit) |-> $past(cfg_gc_en));

  assert_reset_quiet_R9: assert property (@(posedge clk)
    !rst_n |=> (!ack_req && !match_pulse && !rd_dir && !gc_hit && !rx_ready));
endmodule

// File: tb/tb_i2c_addr_match.sv
module tb_i2c_addr_match;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_ten_bit = 1'b0;
  logic [9:0] cfg_own_addr = 10'h2A5;
  logic       cfg_gc_en = 1'b0;
  logic       start_evt = 1'b0;
  logic       stop_evt = 1'b0;
  logic       rx_valid = 1'b0;
  logic       rx_ready;
  logic [7:0] rx_data = 8'h00;
  logic       ack_req, match_pulse, rd_dir, gc_hit;

  int checks = 0;
  int fails = 0;

  typedef struct {
    logic [3:0] exp;   // {ack, match, rd, gc}
    string      req;
  } exp_t;
  exp_t sb_q[$];

  always #5 clk = ~clk;

  i2c_addr_match dut (
    .clk(clk), .rst_n(rst_n), .cfg_ten_bit(cfg_ten_bit), .cfg_own_addr(cfg_own_addr),
    .cfg_gc_en(cfg_gc_en), .start_evt(start_evt), .stop_evt(stop_evt),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .ack_req(ack_req), .match_pulse(match_pulse), .rd_dir(rd_dir), .gc_hit(gc_hit)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {ack,match,rd,gc} actual=%b expected=%b", req, act, exp);
    end
  endtask

  // monitor: each byte seen at an edge has its result checked shortly after that edge
  always @(posedge clk) begin
    if (rx_valid) begin
      #2;
      if (sb_q.size() == 0) begin
        check("R1 unexpected byte", 4'b0000, 4'b1111);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.req, {ack_req, match_pulse, rd_dir, gc_hit}, e.exp);
      end
    end
  end

  task automatic send(input logic [7:0] b, input logic [3:0] exp, input string req,
                      input bit with_start = 1'b0);
    exp_t e;
    e.exp = exp;
    e.req = req;
    sb_q.push_back(e);
    @(negedge clk);
    rx_data   = b;
    rx_valid  = 1'b1;
    start_evt = with_start;
    @(negedge clk);
    rx_valid  = 1'b0;
    start_evt = 1'b0;
  endtask

  task automatic event_pulse(input bit is_stop);
    @(negedge clk);
    if (is_stop) stop_evt = 1'b1; else start_evt = 1'b1;
    @(negedge clk);
    stop_evt  = 1'b0;
    start_evt = 1'b0;
    check("R8 event clears", {ack_req, match_pulse, rd_dir, gc_hit}, 4'b0000);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset outputs", {ack_req, match_pulse, rd_dir, gc_hit}, 4'b0000);
    check("R1 ready low in reset", {3'b000, rx_ready}, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", {3'b000, rx_ready}, 4'b0001);

    // 7-bit, own low bits 0x25 -> write 0x4A, read 0x4B
    event_pulse(1'b0);
    send(8'h4B, 4'b1110, "R2 7-bit read match");
    send(8'h4A, 4'b0010, "R10 byte after match ignored");
    event_pulse(1'b1);
    event_pulse(1'b0);
    send(8'h4A, 4'b1100, "R2 7-bit write match");
    event_pulse(1'b0);
    send(8'h50, 4'b0000, "R3 mismatch");
    send(8'h4A, 4'b0000, "R3 later byte ignored");

    // general call
    cfg_gc_en = 1'b1;
    event_pulse(1'b0);
    send(8'h00, 4'b1101, "R4 general call");
    send(8'h4A, 4'b0001, "R10 gc held");
    event_pulse(1'b1);
    cfg_gc_en = 1'b0;
    cfg_own_addr = 10'h000;
    event_pulse(1'b0);
    send(8'h00, 4'b0000, "R4 gc disabled");
    cfg_own_addr = 10'h2A5;

    // 10-bit: header write 0xF4, low 0xA5, header read 0xF5
    cfg_ten_bit = 1'b1;
    event_pulse(1'b1);
    event_pulse(1'b0);
    send(8'hF5, 4'b0000, "R7 read header unarmed");
    event_pulse(1'b0);
    send(8'hF4, 4'b1000, "R5 header acked");
    send(8'hA5, 4'b1100, "R6 low byte match");
    event_pulse(1'b0);
    send(8'hF5, 4'b1110, "R7 repeated start read");
    event_pulse(1'b1);
    event_pulse(1'b0);
    send(8'hF5, 4'b0000, "R7 disarmed by stop");
    event_pulse(1'b0);
    send(8'hF4, 4'b1000, "R5 header acked again");
    send(8'hA4, 4'b0000, "R6 low mismatch");
    send(8'hA5, 4'b0000, "R6 after mismatch ignored");
    event_pulse(1'b0);
    send(8'hF0, 4'b0000, "R5 wrong high bits");
    event_pulse(1'b0);
    send(8'hF4, 4'b1000, "R5 header ok");
    send(8'hF4, 4'b0000, "R8 byte with start dropped", 1'b1);
    send(8'hF4, 4'b1000, "R8 back to first byte");

    repeat (4) @(negedge clk);
    if (sb_q.size() != 0) check("R1 pending results", 4'b0000, 4'b1111);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule